// File: doc/BRIEF.md
# Dual-Protocol Quad-Channel Host Bus Front End

This block sits between a host processor bus and four UART channel cores. A static mode pin picks one of two bus styles that share the same pins. In strobe style, the host uses separate active-low read and write strobes and one active-low select per channel. In single-select style, one active-low select frames each access. A level on the former write-strobe pin says read (1) or write (0), and two of the former select pins act as channel address bits. Every access is decoded into a channel index, a three-bit register address, a direction and a data byte. Here the channel register banks are stand-in stubs of eight bytes per channel.

The block also produces the interrupt pins. In strobe style there is one pin per channel, gated by bit 3 of register 4 in that channel unless a force input is high. In single-select style there is one open-drain device interrupt, and the other three pins are driven low. An active-low status select puts a packed FIFO status byte on the bus without any address decode. Two combined ready outputs merge the four per-channel active-low ready lines.

All bus pins are sampled on the block clock. Read data and the status byte appear one clock after the pins are sampled. A write takes effect on the clock after the end of the write is sampled. Reset is asynchronous, active low, and its release is synchronised internally over two clocks.

Top module: `quad_host_bus_if`

## Requirements
- R1: With `mode_strobe`=1, when one select `cs_n[i]` is low and `rd_n` is low, `dout_oe` is 1 and `dout` shows register `addr` of channel i. Both take effect one clock after the pins are sampled.
- R2: With `mode_strobe`=1, a write to the selected channel and `addr` stores `din` when `wr_n` rises while the select is held. The new value is readable two clocks later. The same register in other channels is unchanged.
- R3: With `mode_strobe`=0, only `cs_n[0]` frames an access. `wr_n`=1 means read and `wr_n`=0 means write, with the write stored when the access ends. The channel index is {`cs_n[2]`,`cs_n[1]`}. `rd_n` and `cs_n[3]` have no effect.
- R4: Each channel holds eight independent byte registers, selected by `addr`. A write to one address leaves the other addresses of that channel unchanged.
- R5: With `mode_strobe`=1, `int_out[i]` follows `chan_irq[i]`. `int_oe[i]` is 1 exactly when bit 3 of register 4 of channel i is 1, or when `irq_sel` is 1.
- R6: With `mode_strobe`=0, `int_out` is 0000. `int_oe[0]` is 1 when any `chan_irq` bit is 1, which models the open-drain pull-low. `int_oe[3:1]` is 111.
- R7: When `stat_sel_n` is low, then one clock later `dout_oe`=1 and `dout` = {`rxrdy_n[3:0]`, ~`txrdy_n[3:0]`}. The status byte takes priority over any register read, and `addr` has no effect.
- R8: `txrdy_all_n` is 0 when any `txrdy_n` bit is 0, and 1 otherwise. `rxrdy_all_n` follows the same rule from `rxrdy_n`.
- R9: With no select active and `stat_sel_n` high, `dout_oe` is 0 and `dout` is 0. A write strobe pulsed with no select active changes no register.
- R10: After reset, all registers read 0 and `dout_oe` is 0. In strobe style with `irq_sel`=0, `int_oe` is 0000.
- R11: In strobe style, if more than one select is low, the lowest-numbered channel is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strobe | input | 1 | 1: strobe style, 0: single-select style |
| rd_n | input | 1 | Read strobe, active low (strobe style only) |
| wr_n | input | 1 | Write strobe (strobe style) or read/write level (single-select style) |
| cs_n | input | 4 | Per-channel selects; in single-select style bit 0 is the select and bits 2:1 are the channel |
| addr | input | 3 | Register address within the channel |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| dout_oe | output | 1 | Drive enable for the data bus |
| stat_sel_n | input | 1 | Status byte select, active low |
| irq_sel | input | 1 | Forces all interrupt pins enabled in strobe style |
| chan_irq | input | 4 | Interrupt requests from the channel cores |
| txrdy_n | input | 4 | Per-channel transmit-ready, active low |
| rxrdy_n | input | 4 | Per-channel receive-ready, active low |
| int_out | output | 4 | Interrupt pin data values |
| int_oe | output | 4 | Interrupt pin drive enables |
| txrdy_all_n | output | 1 | Combined transmit-ready, active low |
| rxrdy_all_n | output | 1 | Combined receive-ready, active low |

## Verification
A bad channel decode shows one clock after a read starts, as the wrong register byte on `dout`. In single-select style this is how swapped address bits show up. A lost or doubled write commit shows up on the next read of that register, two clocks after the strobe ends. A wrongly set enable bit shows on `int_oe` at once, because the interrupt pins are combinational from that register bit. A wrong status bit order or polarity shows on the cycle after `stat_sel_n` falls. A wrong enable is caught the same way, since `dout_oe` must follow the selects one clock later.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int NCH        = 4;
  localparam int CH_W       = $clog2(NCH);
  localparam int AW         = 3;
  localparam int NREG       = 1 << AW;
  localparam int DW         = 8;
  localparam int MCR_ADDR   = 4;
  localparam int IRQ_EN_BIT = 3;

  typedef struct packed {
    logic            rd;
    logic            wr;
    logic [CH_W-1:0] ch;
    logic [AW-1:0]   ad;
    logic [DW-1:0]   dat;
  } acc_t;
endpackage

// File: rtl/hbi_rst_sync.sv
module hbi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hbi_decode.sv
module hbi_decode
  import hbi_pkg::*;
(
  input  logic           strobe_mode,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [NCH-1:0] cs_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  din,
  output acc_t           acc
);
  logic            hit;
  logic [CH_W-1:0] sel;

  // lowest-numbered active select wins in strobe style
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (!cs_n[i]) begin
        hit = 1'b1;
        sel = CH_W'(i);
      end
    end
  end

  always_comb begin
    acc     = '0;
    acc.ad  = addr;
    acc.dat = din;
    if (strobe_mode) begin
      acc.ch = sel;
      acc.rd = hit & ~rd_n;
      acc.wr = hit & ~wr_n;
    end else begin
      acc.ch = cs_n[CH_W:1];
      acc.rd = ~cs_n[0] & wr_n;
      acc.wr = ~cs_n[0] & ~wr_n;
    end
  end
endmodule

// File: rtl/hbi_regbank.sv
module hbi_regbank
  import hbi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [CH_W-1:0] wch,
  input  logic [AW-1:0]   wad,
  input  logic [DW-1:0]   wdat,
  input  logic [CH_W-1:0] rch,
  input  logic [AW-1:0]   rad,
  output logic [DW-1:0]   rdat,
  output logic [NCH-1:0]  irq_en
);
  logic [DW-1:0] mem_q [NCH][NREG];
  logic          en    [NCH][NREG];

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < NREG; r++) begin
        en[c][r] = we && (wch == CH_W'(c)) && (wad == AW'(r));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < NREG; r++)
          mem_q[c][r] <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < NREG; r++)
          if (en[c][r]) mem_q[c][r] <= wdat;
    end
  end

  assign rdat = mem_q[rch][rad];

  for (genvar g = 0; g < NCH; g++) begin : g_irq_en
    assign irq_en[g] = mem_q[g][MCR_ADDR][IRQ_EN_BIT];
  end
endmodule

// File: rtl/hbi_irq.sv
module hbi_irq
  import hbi_pkg::*;
(
  input  logic           strobe_mode,
  input  logic           irq_sel,
  input  logic [NCH-1:0] irq_en,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] int_out,
  output logic [NCH-1:0] int_oe
);
  for (genvar g = 0; g < NCH; g++) begin : g_pin
    if (g == 0) begin : g_dev
      always_comb begin
        if (strobe_mode) begin
          int_out[g] = req[g];
          int_oe[g]  = irq_en[g] | irq_sel;
        end else begin
          int_out[g] = 1'b0;
          int_oe[g]  = |req;
        end
      end
    end else begin : g_chan
      always_comb begin
        if (strobe_mode) begin
          int_out[g] = req[g];
          int_oe[g]  = irq_en[g] | irq_sel;
        end else begin
          int_out[g] = 1'b0;
          int_oe[g]  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/quad_host_bus_if.sv
module quad_host_bus_if
  import hbi_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_strobe,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [NCH-1:0] cs_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  din,
  output logic [DW-1:0]  dout,
  output logic           dout_oe,
  input  logic           stat_sel_n,
  input  logic           irq_sel,
  input  logic [NCH-1:0] chan_irq,
  input  logic [NCH-1:0] txrdy_n,
  input  logic [NCH-1:0] rxrdy_n,
  output logic [NCH-1:0] int_out,
  output logic [NCH-1:0] int_oe,
  output logic           txrdy_all_n,
  output logic           rxrdy_all_n
);
  logic          rst_i;
  acc_t          acc_d, cur_q, prv_q;
  logic          stat_q;
  logic          wr_commit;
  logic [DW-1:0] rdat;
  logic [NCH-1:0] irq_en;

  hbi_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i)
  );

  hbi_decode u_dec (
    .strobe_mode(mode_strobe), .rd_n(rd_n), .wr_n(wr_n),
    .cs_n(cs_n), .addr(addr), .din(din), .acc(acc_d)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cur_q  <= '0;
      prv_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      cur_q  <= acc_d;
      prv_q  <= cur_q;
      stat_q <= ~stat_sel_n;
    end
  end

  // a write lands when the sampled write phase ends
  assign wr_commit = prv_q.wr & ~cur_q.wr;

  hbi_regbank u_regs (
    .clk(clk), .rst_n(rst_i), .we(wr_commit),
    .wch(prv_q.ch), .wad(prv_q.ad), .wdat(prv_q.dat),
    .rch(cur_q.ch), .rad(cur_q.ad), .rdat(rdat), .irq_en(irq_en)
  );

  always_comb begin
    if (stat_q) begin
      dout    = {rxrdy_n, ~txrdy_n};
      dout_oe = 1'b1;
    end else if (cur_q.rd) begin
      dout    = rdat;
      dout_oe = 1'b1;
    end else begin
      dout    = '0;
      dout_oe = 1'b0;
    end
  end

  hbi_irq u_irq (
    .strobe_mode(mode_strobe), .irq_sel(irq_sel), .irq_en(irq_en),
    .req(chan_irq), .int_out(int_out), .int_oe(int_oe)
  );

  assign txrdy_all_n = &txrdy_n;
  assign rxrdy_all_n = &rxrdy_n;
endmodule

// File: rtl/hbi_chk.sv
module hbi_chk
  import hbi_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           rst_i,
  input logic           mode_strobe,
  input logic           irq_sel,
  input logic [NCH-1:0] cs_n,
  input logic           stat_sel_n,
  input logic [NCH-1:0] chan_irq,
  input logic [NCH-1:0] txrdy_n,
  input logic [NCH-1:0] rxrdy_n,
  input logic [DW-1:0]  dout,
  input logic           dout_oe,
  input logic [NCH-1:0] int_out,
  input logic [NCH-1:0] int_oe,
  input logic           wr_commit
);
  // R9: idle bus leaves data bus undriven
  p_oe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_i)
    ($past(&cs_n) && $past(stat_sel_n)) |-> (!dout_oe && dout == '0));

  // R9: no register commit without a select
  p_no_idle_write_r9: assert property (@(posedge clk) disable iff (!rst_i)
    ($past(&cs_n) && $past(&cs_n, 2)) |-> !wr_commit);

  // R7: status byte one clock after status select
  p_status_byte_r7: assert property (@(posedge clk) disable iff (!rst_i)
    ($past(rst_i) && !$past(stat_sel_n)) |->
      (dout_oe && dout == {rxrdy_n, ~txrdy_n}));

  // R5: force input enables all interrupt pins
  p_int_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_strobe && irq_sel) |-> (&int_oe && int_out == chan_irq));

  // R6: single-select interrupt pins
  p_int_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_strobe |-> (int_out == '0 && int_oe[NCH-1:1] == '1 &&
                      int_oe[0] == (chan_irq != '0)));
endmodule

bind quad_host_bus_if hbi_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rst_i(rst_i), .mode_strobe(mode_strobe),
  .irq_sel(irq_sel), .cs_n(cs_n), .stat_sel_n(stat_sel_n),
  .chan_irq(chan_irq), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n),
  .dout(dout), .dout_oe(dout_oe), .int_out(int_out), .int_oe(int_oe),
  .wr_commit(wr_commit)
);

// File: tb/quad_host_bus_if_tb.sv
`timescale 1ns/1ps
module quad_host_bus_if_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_strobe, rd_n, wr_n, stat_sel_n, irq_sel;
  logic [3:0] cs_n, chan_irq, txrdy_n, rxrdy_n, int_out, int_oe;
  logic [2:0] addr;
  logic [7:0] din, dout;
  logic       dout_oe, txrdy_all_n, rxrdy_all_n;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  quad_host_bus_if dut_i (
    .clk(clk), .rst_n(rst_n), .mode_strobe(mode_strobe), .rd_n(rd_n),
    .wr_n(wr_n), .cs_n(cs_n), .addr(addr), .din(din), .dout(dout),
    .dout_oe(dout_oe), .stat_sel_n(stat_sel_n), .irq_sel(irq_sel),
    .chan_irq(chan_irq), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n),
    .int_out(int_out), .int_oe(int_oe), .txrdy_all_n(txrdy_all_n),
    .rxrdy_all_n(rxrdy_all_n)
  );

  // entry: {op(1=read), mode, chan[1:0], addr[2:0], data[7:0]}
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd0, 3'd0, 8'h11},
    {1'b0, 1'b1, 2'd1, 3'd0, 8'h22},
    {1'b0, 1'b1, 2'd3, 3'd7, 8'hA5},
    {1'b1, 1'b1, 2'd0, 3'd0, 8'h11},
    {1'b1, 1'b1, 2'd1, 3'd0, 8'h22},
    {1'b1, 1'b1, 2'd3, 3'd7, 8'hA5},
    {1'b1, 1'b1, 2'd2, 3'd0, 8'h00},
    {1'b0, 1'b0, 2'd2, 3'd5, 8'h3C},
    {1'b1, 1'b0, 2'd2, 3'd5, 8'h3C},
    {1'b1, 1'b1, 2'd2, 3'd5, 8'h3C},
    {1'b0, 1'b0, 2'd0, 3'd0, 8'h5A},
    {1'b1, 1'b1, 2'd0, 3'd0, 8'h5A},
    {1'b1, 1'b0, 2'd1, 3'd0, 8'h22},
    {1'b0, 1'b1, 2'd1, 3'd1, 8'hFF},
    {1'b1, 1'b0, 2'd1, 3'd1, 8'hFF},
    {1'b1, 1'b0, 2'd1, 3'd0, 8'h22}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rd_n = 1'b1; wr_n = 1'b1; cs_n = 4'hF; stat_sel_n = 1'b1;
  endtask

  task automatic bus_write(input logic m, input logic [1:0] ch,
                           input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    mode_strobe = m; addr = a; din = d; wr_n = 1'b0;
    cs_n = m ? ~(4'b0001 << ch) : {1'b1, ch, 1'b0};
    @(negedge clk);
    wr_n = 1'b1;
    if (!m) cs_n = 4'hF;
    @(negedge clk);
    idle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bus_read(input logic m, input logic [1:0] ch, input logic [2:0] a,
                          input logic [7:0] exp, input string tag);
    @(negedge clk);
    mode_strobe = m; addr = a;
    if (m) begin cs_n = ~(4'b0001 << ch); rd_n = 1'b0; end
    else   begin cs_n = {1'b1, ch, 1'b0}; wr_n = 1'b1; end
    @(negedge clk);
    check({tag, " oe"}, {7'd0, dout_oe}, 8'h01);
    check({tag, " data"}, dout, exp);
    idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_strobe = 1'b1; irq_sel = 1'b0; addr = '0; din = '0;
    chan_irq = 4'b1011; txrdy_n = 4'hF; rxrdy_n = 4'hF;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    check("R10 oe", {7'd0, dout_oe}, 8'h00);
    check("R10 int_oe", {4'd0, int_oe}, 8'h00);
    check("R5 int_out", {4'd0, int_out}, 8'h0B);
    bus_read(1'b1, 2'd3, 3'd4, 8'h00, "R10 reg");

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      logic [14:0] e;
      e = VEC[i];
      if (e[14]) bus_read(e[13], e[12:11], e[10:8], e[7:0], e[13] ? "R1/R4 read" : "R3 read");
      else       bus_write(e[13], e[12:11], e[10:8], e[7:0]);
    end

    // R9: write strobe with no select
    @(negedge clk);
    mode_strobe = 1'b1; addr = 3'd0; din = 8'hEE; wr_n = 1'b0;
    @(negedge clk);
    check("R9 oe idle", {7'd0, dout_oe}, 8'h00);
    check("R9 dout idle", dout, 8'h00);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(1'b1, 2'd0, 3'd0, 8'h5A, "R9 unchanged");

    // R3: rd_n and cs_n[3] ignored in single-select style
    @(negedge clk);
    mode_strobe = 1'b0; rd_n = 1'b0; cs_n = 4'b0111; wr_n = 1'b1;
    @(negedge clk);
    check("R3 ignored pins oe", {7'd0, dout_oe}, 8'h00);
    wr_n = 1'b0; din = 8'h99;
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    bus_read(1'b0, 2'd0, 3'd0, 8'h5A, "R3 no write via cs3");

    // R11: two selects low, lowest channel wins
    @(negedge clk);
    mode_strobe = 1'b1; addr = 3'd0; cs_n = 4'b1100; rd_n = 1'b0;
    @(negedge clk);
    check("R11 priority", dout, 8'h5A);
    idle();

    // R7: status byte overrides a read, no address needed
    @(negedge clk);
    txrdy_n = 4'b1010; rxrdy_n = 4'b0110;
    cs_n = 4'b1110; rd_n = 1'b0; addr = 3'd6; stat_sel_n = 1'b0;
    @(negedge clk);
    check("R7 status oe", {7'd0, dout_oe}, 8'h01);
    check("R7 status byte", dout, 8'h65);
    idle();
    // R8: combined ready
    check("R8 tx any low", {7'd0, txrdy_all_n}, 8'h00);
    check("R8 rx any low", {7'd0, rxrdy_all_n}, 8'h00);
    @(negedge clk);
    txrdy_n = 4'h0; rxrdy_n = 4'hF; stat_sel_n = 1'b0;
    @(negedge clk);
    check("R7 status byte 2", dout, 8'hFF);
    check("R8 rx all high", {7'd0, rxrdy_all_n}, 8'h01);
    txrdy_n = 4'hF;
    #1 check("R8 tx all high", {7'd0, txrdy_all_n}, 8'h01);
    idle();
    @(negedge clk);

    // R5: enable bit in register 4 of channel 2
    bus_write(1'b1, 2'd2, 3'd4, 8'h08);
    check("R5 int_oe by reg", {4'd0, int_oe}, 8'h04);
    irq_sel = 1'b1;
    #1 check("R5 int_oe forced", {4'd0, int_oe}, 8'h0F);

    // R6: single-select interrupts
    mode_strobe = 1'b0; irq_sel = 1'b0; chan_irq = 4'b0000;
    #1 check("R6 oe no req", {4'd0, int_oe}, 8'h0E);
    check("R6 out", {4'd0, int_out}, 8'h00);
    chan_irq = 4'b0100;
    #1 check("R6 oe req", {4'd0, int_oe}, 8'h0F);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule